// File: doc/BRIEF.md
# Reference Divider with Dual Tap Select

This block turns a fast reference clock into the two slow comparison pulse trains that a pair of phase detectors needs. A programmable first stage divides the reference by R. Its terminal count then clocks a four-stage binary chain, which makes five candidate pulse trains with periods R, 2R, 4R, 8R and 16R reference cycles. Every candidate pulse is one reference cycle wide and falls on a terminal count of the first stage. A longer-period train therefore always fires together with every shorter one when the chain rolls over.

Two independent 3-bit selectors each pick one of the five trains: one for the main phase detector and one for the auxiliary phase detector. The two selectors use opposite code orders. A given tap is reached by a code k on the main side and by code 4-k on the auxiliary side. The divide ratio can be changed at any time. The first stage picks up the new value only at its own terminal count, so a count already running is never cut short or stretched.

Top module: `ref_tap_divider`

## Requirements
- R1: While `rst` is sampled high, and in the cycle after each such edge, `main_pulse` and `aux_pulse` are both low. Reset starts the first stage and the chain from zero and loads the divide ratio from `r_div`.
- R2: With main code 000, `main_pulse` is high for exactly one cycle every R cycles. The first pulse appears after the R-th rising edge that follows reset release.
- R3: Main code k, for k from 0 to 4, selects the train of period R·2^k. Its pulses come after edges R·2^k, 2·R·2^k, and so on, counted from reset release.
- R4: Auxiliary code c, for c from 0 to 4, selects the train of period R·2^(4−c). Auxiliary 100 gives period R, and auxiliary 000 gives period 16R.
- R5: Codes 101, 110 and 111 on either selector keep that output low.
- R6: Each output pulse is one cycle wide and follows a first-stage terminal count. At every chain rollover (a multiple of 16R) all five trains pulse in the same cycle.
- R7: A new `r_div` value does not change the count that is running. It is loaded at the next terminal count and sets the spacing from there on.
- R8: Values of `r_div` below 4 are treated as 4.
- R9: The main and auxiliary selections act independently. Each output follows only its own code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| r_div | input | 10 | First-stage divide ratio R (4 to 1023) |
| main_sel | input | 3 | Main tap code (000 = R … 100 = 16R) |
| aux_sel | input | 3 | Auxiliary tap code (100 = R … 000 = 16R) |
| main_pulse | output | 1 | Selected pulse for the main phase detector |
| aux_pulse | output | 1 | Selected pulse for the auxiliary phase detector |

## Verification
Two events can fall in the same cycle: a first-stage terminal count that reloads a new ratio, and a chain rollover where all five taps fire together. The bench provokes this by changing `r_div` a few cycles before the sixteenth terminal count. Both outputs are pointed at the taps that meet there: main at 16R and auxiliary at R. The expected pulse times are computed arithmetically from the old ratio up to the reload and from the new ratio after it. Both outputs must pulse together at the reload edge, and the later spacing must follow only the new ratio, counted from a chain that restarts at zero.

// File: rtl/ref_tap_pkg.sv
package ref_tap_pkg;

    localparam int R_W    = 10;
    localparam int STAGES = 4;
    localparam int TAPS   = STAGES + 1;
    localparam int SEL_W  = 3;
    localparam int R_MIN  = 4;

    typedef enum logic {
        ORDER_ASC  = 1'b0,
        ORDER_DESC = 1'b1
    } tap_order_e;

    typedef struct packed {
        logic main;
        logic aux;
    } ref_pair_t;

    // code that reaches a given tap under a given ordering
    function automatic int tap_code(input int tap, input int taps, input tap_order_e ord);
        if (ord == ORDER_DESC) begin
            return taps - 1 - tap;
        end
        return tap;
    endfunction

endpackage

// File: rtl/rdiv_stage.sv
module rdiv_stage #(
    parameter int R_W   = ref_tap_pkg::R_W,
    parameter int R_MIN = ref_tap_pkg::R_MIN
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [R_W-1:0] r_req,
    output logic           tc
);
    localparam logic [R_W-1:0] R_FLOOR = R_W'(R_MIN);

    logic [R_W-1:0] cnt;
    logic [R_W-1:0] r_act;
    logic [R_W-1:0] r_next;

    assign r_next = (r_req < R_FLOOR) ? R_FLOOR : r_req;
    assign tc     = (cnt == r_act - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            r_act <= r_next;
        end else if (tc) begin
            cnt   <= '0;
            r_act <= r_next;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tap_chain.sv
module tap_chain #(
    parameter int STAGES = ref_tap_pkg::STAGES,
    localparam int TAPS  = STAGES + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tc,
    output logic [TAPS-1:0] taps
);
    logic [STAGES-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (tc) begin
            q <= q + 1'b1;
        end
    end

    assign taps[0] = tc;
    for (genvar k = 1; k < TAPS; k++) begin : g_stage
        assign taps[k] = taps[k-1] & q[k-1];
    end
endmodule

// File: rtl/tap_mux.sv
module tap_mux #(
    parameter int                     TAPS  = ref_tap_pkg::TAPS,
    parameter int                     SEL_W = ref_tap_pkg::SEL_W,
    parameter ref_tap_pkg::tap_order_e ORDER = ref_tap_pkg::ORDER_ASC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TAPS-1:0]  taps,
    input  logic [SEL_W-1:0] sel,
    output logic             pulse
);
    logic [TAPS-1:0] hit;
    logic            pick;

    for (genvar g = 0; g < TAPS; g++) begin : g_dec
        assign hit[g] = (int'(sel) == ref_tap_pkg::tap_code(g, TAPS, ORDER));
    end

    assign pick = |(hit & taps);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= 1'b0;
        end else begin
            pulse <= pick;
        end
    end
endmodule

// File: rtl/ref_tap_divider.sv
module ref_tap_divider #(
    parameter int R_W    = ref_tap_pkg::R_W,
    parameter int STAGES = ref_tap_pkg::STAGES,
    parameter int SEL_W  = ref_tap_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [R_W-1:0]   r_div,
    input  logic [SEL_W-1:0] main_sel,
    input  logic [SEL_W-1:0] aux_sel,
    output logic             main_pulse,
    output logic             aux_pulse
);
    import ref_tap_pkg::*;

    localparam int NTAPS = STAGES + 1;

    logic             tc;
    logic [NTAPS-1:0] taps;
    ref_pair_t        outs;

    rdiv_stage #(.R_W(R_W), .R_MIN(R_MIN)) u_rdiv (
        .clk   (clk),
        .rst   (rst),
        .r_req (r_div),
        .tc    (tc)
    );

    tap_chain #(.STAGES(STAGES)) u_chain (
        .clk  (clk),
        .rst  (rst),
        .tc   (tc),
        .taps (taps)
    );

    tap_mux #(.TAPS(NTAPS), .SEL_W(SEL_W), .ORDER(ORDER_ASC)) u_main_mux (
        .clk   (clk),
        .rst   (rst),
        .taps  (taps),
        .sel   (main_sel),
        .pulse (outs.main)
    );

    tap_mux #(.TAPS(NTAPS), .SEL_W(SEL_W), .ORDER(ORDER_DESC)) u_aux_mux (
        .clk   (clk),
        .rst   (rst),
        .taps  (taps),
        .sel   (aux_sel),
        .pulse (outs.aux)
    );

    assign main_pulse = outs.main;
    assign aux_pulse  = outs.aux;
endmodule

// File: rtl/ref_tap_divider_chk.sv
module ref_tap_divider_chk #(
    parameter int TAPS  = ref_tap_pkg::TAPS,
    parameter int SEL_W = ref_tap_pkg::SEL_W
) (
    input logic             clk,
    input logic             rst,
    input logic [SEL_W-1:0] main_sel,
    input logic [SEL_W-1:0] aux_sel,
    input logic             main_pulse,
    input logic             aux_pulse,
    input logic             tc
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!main_pulse && !aux_pulse)); // R1

    AST_MAIN_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
        main_pulse |=> !main_pulse); // R2

    AST_AUX_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
        aux_pulse |=> !aux_pulse); // R6

    AST_MAIN_INVALID_LOW: assert property (@(posedge clk) disable iff (rst)
        (int'(main_sel) >= TAPS) |=> !main_pulse); // R5

    AST_AUX_INVALID_LOW: assert property (@(posedge clk) disable iff (rst)
        (int'(aux_sel) >= TAPS) |=> !aux_pulse); // R5

    AST_MIRROR_CODES: assert property (@(posedge clk) disable iff (rst)
        ((int'(main_sel) < TAPS) && (int'(aux_sel) < TAPS) &&
         (int'(main_sel) + int'(aux_sel) == TAPS - 1))
        |=> (main_pulse == aux_pulse)); // R4

    AST_ON_TERMINAL: assert property (@(posedge clk) disable iff (rst)
        (main_pulse || aux_pulse) |-> $past(tc)); // R6
endmodule

bind ref_tap_divider ref_tap_divider_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .main_sel   (main_sel),
    .aux_sel    (aux_sel),
    .main_pulse (main_pulse),
    .aux_pulse  (aux_pulse),
    .tc         (tc)
);

// File: tb/test_ref_tap_divider.sv
module test_ref_tap_divider;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] r_div = 10'd4;
    logic [2:0] main_sel = 3'd0;
    logic [2:0] aux_sel = 3'd0;
    logic       main_pulse;
    logic       aux_pulse;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    ref_tap_divider i_ref_tap_divider (
        .clk        (clk),
        .rst        (rst),
        .r_div      (r_div),
        .main_sel   (main_sel),
        .aux_sel    (aux_sel),
        .main_pulse (main_pulse),
        .aux_pulse  (aux_pulse)
    );

    function automatic int eff(input int r);
        return (r < 4) ? 4 : r;
    endfunction

    // expected pulse after edge t for tap k (k<0: invalid code)
    function automatic bit expect_pulse(input int t, input int k, input int r0,
                                        input int r1, input int tchg);
        int t0;
        int n;
        if (k < 0) return 1'b0;
        if (tchg <= 0) t0 = 1 << 30;
        else t0 = ((tchg / r0) + 1) * r0;
        if (t <= t0) begin
            if (t % r0 != 0) return 1'b0;
            n = t / r0;
        end else begin
            if ((t - t0) % r1 != 0) return 1'b0;
            n = t0 / r0 + (t - t0) / r1;
        end
        return (n % (1 << k)) == 0;
    endfunction

    task automatic check(input bit act, input bit exp, input string tag, input int t);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at edge %0d: got %0b expected %0b", tag, t, act, exp);
        end
    endtask

    task automatic run(input int r0_raw, input int r1_raw, input int tchg,
                       input int msel, input int asel, input int ncyc, input string tag);
        int r0 = eff(r0_raw);
        int r1 = eff(r1_raw);
        int mk = (msel <= 4) ? msel : -1;
        int ak = (asel <= 4) ? 4 - asel : -1;
        @(negedge clk);
        rst = 1'b1;
        r_div = 10'(r0_raw);
        main_sel = 3'(msel);
        aux_sel = 3'(asel);
        @(posedge clk);
        @(posedge clk);
        #1;
        check(main_pulse, 1'b0, "R1 main in reset", 0);
        check(aux_pulse, 1'b0, "R1 aux in reset", 0);
        @(negedge clk);
        rst = 1'b0;
        for (int t = 1; t <= ncyc; t++) begin
            @(posedge clk);
            #1;
            check(main_pulse, expect_pulse(t, mk, r0, r1, tchg), {tag, " main"}, t);
            check(aux_pulse, expect_pulse(t, ak, r0, r1, tchg), {tag, " aux"}, t);
            if (t == tchg) r_div = 10'(r1_raw);
        end
    endtask

    initial begin
        int rs[4] = '{4, 5, 7, 13};
        foreach (rs[i]) begin
            for (int m = 0; m < 8; m++) begin
                int a = (m + 3) % 8;
                string tg;
                if (m > 4 || a > 4) tg = "R5 R9 R3 R4";
                else if (m == 0) tg = "R2 R4 R9";
                else tg = "R3 R4 R9";
                run(rs[i], rs[i], 0, m, a, 48 * rs[i] + 4, tg);
            end
            // mirrored codes: both outputs must track each other
            run(rs[i], rs[i], 0, 2, 2, 40 * rs[i], "R4 R6");
        end
        // all taps together at rollover
        run(6, 6, 0, 4, 4, 200, "R6 rollover");
        // small ratios clamp to 4
        run(1, 1, 0, 0, 3, 100, "R8 clamp r1");
        run(0, 0, 0, 1, 4, 100, "R8 clamp r0");
        // ratio change mid-count, effective at next terminal count
        run(6, 9, 8, 0, 7, 80, "R7 mid-count");
        run(9, 5, 3, 1, 2, 200, "R7 lower ratio");
        // ratio change landing on chain rollover
        run(4, 5, 62, 4, 4, 240, "R7 R6 reload at rollover");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not end, got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule